// File: doc/BRIEF.md
# FIFO DMA Request Handshake Controller

This block sits between a demand-mode DMA controller and a peripheral's transmit and receive FIFOs. It drives a separate level request line for each direction and takes one acknowledge input that both directions share. The active-low write strobe, read strobe, chip select and acknowledge are sampled on the system clock. From them the block decodes each bus cycle into a FIFO push, a FIFO pop or a write to the block-length registers. It then decides when each request line rises, drops and rises again while a block is moved.

When the acknowledge input is low, every bus cycle goes to the top of the FIFO for its direction, and address and chip select are not looked at. When it is high, the FIFO is an ordinary addressed location. The host starts a transmit block by writing a 16-bit byte count as two bytes. The request drops early, at the write that completes the second-to-last byte of the block and at the write that completes byte 63 of every 64-byte chunk. It comes back on the next rising acknowledge edge. This keeps the handshake safe for slow and for fast DMA controllers. A receive block starts when the FIFO side reports a ready block and its length, and it follows the same rules on the read strobe.

Top module: `fifo_dma_req_ctrl`

## Requirements
- R1: `drq_tx` and `drq_rx` are independent outputs, and a block running in one direction never raises the other direction's request.
- R2: While `dack_n` is 0, the rising edge of `wr_n` gives one `tx_push` pulse and the rising edge of `rd_n` gives one `rx_pop` pulse, whatever `cs_n` and `addr` hold. Such a write never loads the length registers.
- R3: While `dack_n` is 1, a strobe reaches the FIFO only when `cs_n` is 0 and `addr` is 0. Any other address, or `cs_n` at 1, produces no push or pop.
- R4: A write to address 1 stores the low length byte. A write to address 2 supplies the high byte and starts a transmit block of n = {high, low} bytes. It raises `drq_tx` when n > 0 and leaves it low when n = 0. The request stays high during the block except as R5 to R8 state.
- R5: `drq_tx` drops on the write that completes transfer n-1 of the block.
- R6: In a block of more than 64 bytes, `drq_tx` also drops on the write that completes transfers 63, 127, and so on (every k*64-1).
- R7: After an early drop, the next rising edge of `dack_n` raises `drq_tx` again if the byte that follows the drop is still to be moved.
- R8: After the last byte of a block, `drq_tx` stays low. If a fast controller moves the byte that follows a drop before the acknowledge rises, `drq_tx` stays low through that rising edge until a new block is started.
- R9: A one-cycle `rx_blk_ready` pulse starts a receive block of `rx_blk_len` bytes and raises `drq_rx`. Reads follow the rules of R5 to R8. A `rx_blk_ready` pulse that arrives while a receive block is running is ignored.
- R10: A rising strobe edge takes effect on the outputs at the third rising clock edge after it: two synchronizer stages, then one register.
- R11: A synchronous active-high `rst` clears both requests, all counters and both block-active flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Asynchronous active-low write strobe |
| rd_n | input | 1 | Asynchronous active-low read strobe |
| cs_n | input | 1 | Asynchronous active-low chip select |
| dack_n | input | 1 | Asynchronous active-low DMA acknowledge, shared by both directions |
| addr | input | ADDR_W (4) | Register address, used only when acknowledge is high |
| wdata | input | DATA_W (8) | Write data, used for the length bytes |
| rx_blk_ready | input | 1 | Pulse: the receive FIFO holds a block to transfer |
| rx_blk_len | input | CNT_W (16) | Byte count of the ready receive block |
| drq_tx | output | 1 | Transmit DMA request (level) |
| drq_rx | output | 1 | Receive DMA request (level) |
| tx_push | output | 1 | One-cycle push strobe to the transmit FIFO |
| rx_pop | output | 1 | One-cycle pop strobe to the receive FIFO |

## Verification
Every push, pop and request change lands at the third rising clock edge after the strobe or acknowledge edge that causes it. A one-cycle `rx_blk_ready` pulse is the exception: it raises the receive request one edge later. The bench drives all inputs on falling edges and samples at least five cycles after each stimulus, once the result has settled. It also makes one directed check that the request is still high two falling edges after the strobe rises and low at the third. Push and pop pulses are counted on every clock and compared with the number of transfers that should reach the FIFO. The expected request level after transfer i of an n-byte block comes from a bench function of i and n alone.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
   // bit positions of the synchronized strobe vector
   localparam int SI_WR  = 0;
   localparam int SI_RD  = 1;
   localparam int SI_CS  = 2;
   localparam int SI_ACK = 3;
   localparam int SI_NUM = 4;

   // what a completed bus cycle was decoded as
   typedef struct packed {
      logic ack;   // acknowledge was low during the strobe
      logic cs;    // chip select was low during the strobe
   } bus_sel_t;
endpackage

// File: rtl/dma_strobe_sync.sv
module dma_strobe_sync #(
   parameter int N      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] async_in,
   output logic [N-1:0] level,
   output logic [N-1:0] rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dma_strobe_sync: STAGES must be at least 2");
      end
      if (N < 1) begin : g_bad_width
         $error("dma_strobe_sync: N must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][N-1:0] stg;
   logic [N-1:0]             prev;

   // all inputs are active-low, so the idle value after reset is all ones
   always_ff @(posedge clk) begin
      if (rst) begin
         stg  <= '1;
         prev <= '1;
      end else begin
         stg  <= {stg[STAGES-2:0], async_in};
         prev <= stg[STAGES-1];
      end
   end

   assign level = stg[STAGES-1];
   assign rise  = stg[STAGES-1] & ~prev;
endmodule

// File: rtl/dma_dir_ctrl.sv
module dma_dir_ctrl #(
   parameter int CNT_W   = 16,
   parameter int CHUNK_W = 6,
   parameter bit CHUNKED = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   input  logic             xfer,
   input  logic             ack_rise,
   output logic             req,
   output logic             active
);
   generate
      if (CHUNK_W < 1 || CHUNK_W >= CNT_W) begin : g_bad_chunk
         $error("dma_dir_ctrl: CHUNK_W must be in 1..CNT_W-1");
      end
   endgenerate

   localparam logic [CNT_W-1:0]   CNT_ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0]   CNT_TWO   = CNT_W'(2);
   localparam logic [CHUNK_W-1:0] POS_ONE   = CHUNK_W'(1);
   localparam logic [CHUNK_W-1:0] POS_PRE   = {{(CHUNK_W-1){1'b1}}, 1'b0};

   logic [CNT_W-1:0]   remain;
   logic [CHUNK_W-1:0] pos;
   logic [CHUNK_W-1:0] pos_nx;
   logic               pending;
   logic               chunk_end;
   logic               last_xfer;
   logic               penult_xfer;

   assign pos_nx      = pos + POS_ONE;
   assign last_xfer   = (remain == CNT_ONE);
   assign penult_xfer = (remain == CNT_TWO);

   generate
      if (CHUNKED) begin : g_chunk_rule
         assign chunk_end = &pos_nx;
      end else begin : g_no_chunk_rule
         assign chunk_end = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         active  <= 1'b0;
         req     <= 1'b0;
         pending <= 1'b0;
         remain  <= '0;
         pos     <= '0;
      end else if (start) begin
         active  <= (len != '0);
         req     <= (len != '0);
         pending <= 1'b0;
         remain  <= len;
         pos     <= '0;
      end else if (xfer && active) begin
         remain <= remain - CNT_ONE;
         pos    <= pos_nx;
         if (last_xfer) begin
            active  <= 1'b0;
            req     <= 1'b0;
            pending <= 1'b0;
         end else if (pending) begin
            // fast controller moved the byte after the drop: stay low
            pending <= 1'b0;
         end else if (penult_xfer || chunk_end) begin
            req     <= 1'b0;
            pending <= 1'b1;
         end
      end else if (ack_rise && pending && active) begin
         req     <= 1'b1;
         pending <= 1'b0;
      end
   end

   // R4: a request is only raised inside a running block
   p_req_in_block_r4: assert property (@(posedge clk) disable iff (rst)
      req |-> active);

   // R5: drop at transfer n-1
   p_drop_penult_r5: assert property (@(posedge clk) disable iff (rst)
      (active && xfer && !start && !pending && penult_xfer) |=> !req);

   // R7: re-arm on acknowledge rise
   p_rearm_ack_r7: assert property (@(posedge clk) disable iff (rst)
      (active && pending && ack_rise && !xfer && !start) |=> req);

   // R8: last byte ends the block
   p_block_done_r8: assert property (@(posedge clk) disable iff (rst)
      (active && xfer && !start && last_xfer) |=> (!active && !req));

   // R8: byte moved while dropped keeps the request low
   p_fast_stays_low_r8: assert property (@(posedge clk) disable iff (rst)
      (active && pending && xfer && !start) |=> !req);

   generate
      if (CHUNKED) begin : g_chunk_assert
         // R6: drop at transfer k*64-1
         p_drop_chunk_r6: assert property (@(posedge clk) disable iff (rst)
            (active && xfer && !start && !pending && !last_xfer && pos == POS_PRE)
            |=> !req);
      end
   endgenerate
endmodule

// File: rtl/fifo_dma_req_ctrl.sv
module fifo_dma_req_ctrl
   import dma_hs_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 16,
   parameter int CHUNK_W     = 6,
   parameter int SYNC_STAGES = 2,
   parameter int FIFO_ADDR   = 0,
   parameter int LEN_LO_ADDR = 1,
   parameter int LEN_HI_ADDR = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic              cs_n,
   input  logic              dack_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rx_blk_ready,
   input  logic [CNT_W-1:0]  rx_blk_len,
   output logic              drq_tx,
   output logic              drq_rx,
   output logic              tx_push,
   output logic              rx_pop
);
   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
         $error("fifo_dma_req_ctrl: CNT_W must equal two data bytes");
      end
      if (FIFO_ADDR == LEN_LO_ADDR || FIFO_ADDR == LEN_HI_ADDR ||
          LEN_LO_ADDR == LEN_HI_ADDR) begin : g_bad_map
         $error("fifo_dma_req_ctrl: register addresses must differ");
      end
      if (FIFO_ADDR >= (1 << ADDR_W) || LEN_LO_ADDR >= (1 << ADDR_W) ||
          LEN_HI_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("fifo_dma_req_ctrl: address out of range");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_FIFO = ADDR_W'(FIFO_ADDR);
   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(LEN_LO_ADDR);
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(LEN_HI_ADDR);

   logic [SI_NUM-1:0] raw_in, lvl, rise;
   assign raw_in[SI_WR]  = wr_n;
   assign raw_in[SI_RD]  = rd_n;
   assign raw_in[SI_CS]  = cs_n;
   assign raw_in[SI_ACK] = dack_n;

   dma_strobe_sync #(.N(SI_NUM), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_in(raw_in),
      .level   (lvl),
      .rise    (rise)
   );

   // capture of the bus cycle while a strobe is held low
   bus_sel_t          cap_sel;
   logic [ADDR_W-1:0] cap_addr;
   logic [DATA_W-1:0] cap_data;
   logic [DATA_W-1:0] len_lo;

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_sel  <= '0;
         cap_addr <= '0;
         cap_data <= '0;
      end else if (!lvl[SI_WR] || !lvl[SI_RD]) begin
         cap_sel.ack <= !lvl[SI_ACK];
         cap_sel.cs  <= !lvl[SI_CS];
         cap_addr    <= addr;
         cap_data    <= wdata;
      end
   end

   logic fifo_sel, reg_sel;
   logic tx_xfer, rx_xfer, lo_wr, tx_start, rx_start;
   logic tx_active, rx_active;
   logic [CNT_W-1:0] tx_len;

   assign fifo_sel = cap_sel.ack || (cap_sel.cs && cap_addr == A_FIFO);
   assign reg_sel  = !cap_sel.ack && cap_sel.cs;
   assign tx_xfer  = rise[SI_WR] && fifo_sel;
   assign rx_xfer  = rise[SI_RD] && fifo_sel;
   assign lo_wr    = rise[SI_WR] && reg_sel && cap_addr == A_LO;
   assign tx_start = rise[SI_WR] && reg_sel && cap_addr == A_HI;
   assign tx_len   = {cap_data, len_lo};
   assign rx_start = rx_blk_ready && !rx_active;

   always_ff @(posedge clk) begin
      if (rst) begin
         len_lo  <= '0;
         tx_push <= 1'b0;
         rx_pop  <= 1'b0;
      end else begin
         if (lo_wr) len_lo <= cap_data;
         tx_push <= tx_xfer;
         rx_pop  <= rx_xfer;
      end
   end

   dma_dir_ctrl #(.CNT_W(CNT_W), .CHUNK_W(CHUNK_W), .CHUNKED(1'b1)) u_tx (
      .clk     (clk),
      .rst     (rst),
      .start   (tx_start),
      .len     (tx_len),
      .xfer    (tx_xfer),
      .ack_rise(rise[SI_ACK]),
      .req     (drq_tx),
      .active  (tx_active)
   );

   dma_dir_ctrl #(.CNT_W(CNT_W), .CHUNK_W(CHUNK_W), .CHUNKED(1'b1)) u_rx (
      .clk     (clk),
      .rst     (rst),
      .start   (rx_start),
      .len     (rx_blk_len),
      .xfer    (rx_xfer),
      .ack_rise(rise[SI_ACK]),
      .req     (drq_rx),
      .active  (rx_active)
   );

   // R2: an acknowledged write never loads the length registers
   p_ack_no_reg_r2: assert property (@(posedge clk) disable iff (rst)
      (rise[SI_WR] && cap_sel.ack) |=> $stable(len_lo));
endmodule

// File: tb/fifo_dma_req_ctrl_test.sv
module fifo_dma_req_ctrl_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        wr_n, rd_n, cs_n, dack_n;
   logic [3:0]  addr;
   logic [7:0]  wdata;
   logic        rx_blk_ready;
   logic [15:0] rx_blk_len;
   logic        drq_tx, drq_rx, tx_push, rx_pop;

   int n_chk  = 0;
   int n_fail = 0;
   int tx_pushes = 0;
   int rx_pops   = 0;
   int wd_cnt    = 0;

   always #2 clk = ~clk;

   fifo_dma_req_ctrl uut (
      .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .cs_n(cs_n),
      .dack_n(dack_n), .addr(addr), .wdata(wdata),
      .rx_blk_ready(rx_blk_ready), .rx_blk_len(rx_blk_len),
      .drq_tx(drq_tx), .drq_rx(drq_rx), .tx_push(tx_push), .rx_pop(rx_pop)
   );

   always @(posedge clk) begin
      if (rst) begin
         tx_pushes <= 0;
         rx_pops   <= 0;
      end else begin
         if (tx_push) tx_pushes <= tx_pushes + 1;
         if (rx_pop)  rx_pops   <= rx_pops + 1;
      end
   end

   always @(posedge clk) begin
      wd_cnt <= wd_cnt + 1;
      if (wd_cnt == 190000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", wd_cnt);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   function automatic bit early_drop(int i, int n);
      return (i == n - 1) || (i % 64 == 63);
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic chk_n(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic bus_write(logic [3:0] a, logic [7:0] d);
      addr = a; wdata = d; cs_n = 1'b0;
      cyc(1); wr_n = 1'b0; cyc(3); wr_n = 1'b1; cyc(4); cs_n = 1'b1; cyc(2);
   endtask

   task automatic bus_read(logic [3:0] a);
      addr = a; cs_n = 1'b0;
      cyc(1); rd_n = 1'b0; cyc(3); rd_n = 1'b1; cyc(4); cs_n = 1'b1; cyc(2);
   endtask

   task automatic dma_write();
      addr = 4'($urandom_range(0, 15)); cs_n = 1'($urandom_range(0, 1));
      dack_n = 1'b0; cyc(1); wr_n = 1'b0; cyc(3); wr_n = 1'b1; cyc(5);
   endtask

   task automatic dma_read();
      dack_n = 1'b0; cyc(1); rd_n = 1'b0; cyc(3); rd_n = 1'b1; cyc(5);
   endtask

   task automatic ack_release();
      dack_n = 1'b1; cs_n = 1'b1; cyc(5);
   endtask

   task automatic tx_start(int n);
      bus_write(4'd1, 8'(n));
      bus_write(4'd2, 8'(n >> 8));
   endtask

   task automatic tx_block(int n, int fast_pct);
      int base;
      base = tx_pushes;
      tx_start(n);
      chk("R4 request after length write", drq_tx, n > 0);
      for (int i = 1; i <= n; i++) begin
         dma_write();
         if (i == n) begin
            chk("R8 low after last byte", drq_tx, 1'b0);
            ack_release();
            chk("R8 stays low after final ack", drq_tx, 1'b0);
         end else if (early_drop(i, n)) begin
            chk((i == n - 1) ? "R5 drop at n-1" : "R6 drop at k*64-1", drq_tx, 1'b0);
            if ($urandom_range(0, 99) < fast_pct) begin
               dma_write();
               chk("R8 fast byte keeps low", drq_tx, 1'b0);
               ack_release();
               chk("R8 no re-arm after fast byte", drq_tx, 1'b0);
               chk_n("R2 pushes in fast block", tx_pushes - base, i + 1);
               return;
            end
            ack_release();
            chk("R7 re-arm on ack rise", drq_tx, 1'b1);
         end else begin
            chk("R4 request held mid-block", drq_tx, 1'b1);
            ack_release();
         end
      end
      chk_n("R2 pushes per block", tx_pushes - base, n);
   endtask

   initial begin
      int base;
      rst = 1'b1; wr_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1; dack_n = 1'b1;
      addr = '0; wdata = '0; rx_blk_ready = 1'b0; rx_blk_len = '0;
      void'($urandom(32'd1234));
      cyc(4);
      rst = 1'b0;
      cyc(2);
      chk("R11 drq_tx after reset", drq_tx, 1'b0);
      chk("R11 drq_rx after reset", drq_rx, 1'b0);
      chk_n("R11 no push after reset", tx_pushes, 0);

      // R3: addressed FIFO access and decoys
      bus_write(4'd0, 8'h5A);
      chk_n("R3 addressed FIFO write pushes", tx_pushes, 1);
      bus_write(4'd5, 8'h11);
      chk_n("R3 other address no push", tx_pushes, 1);
      addr = 4'd0; cyc(1); wr_n = 1'b0; cyc(3); wr_n = 1'b1; cyc(5);
      chk_n("R3 chip select high no push", tx_pushes, 1);
      bus_read(4'd0);
      chk_n("R3 addressed FIFO read pops", rx_pops, 1);

      // R2: acknowledged write to length address pushes but starts nothing
      base = tx_pushes;
      bus_write(4'd1, 8'd7);
      addr = 4'd2; cs_n = 1'b0; dack_n = 1'b0; wdata = 8'h00;
      cyc(1); wr_n = 1'b0; cyc(3); wr_n = 1'b1; cyc(5);
      ack_release();
      chk_n("R2 ack write pushes", tx_pushes - base, 1);
      chk("R2 ack write starts no block", drq_tx, 1'b0);

      // R10: exact latency of the drop
      tx_start(2);
      chk("R4 start n=2", drq_tx, 1'b1);
      dack_n = 1'b0; cyc(1); wr_n = 1'b0; cyc(3); wr_n = 1'b1;
      cyc(2);
      chk("R10 still high two edges after strobe", drq_tx, 1'b1);
      cyc(1);
      chk("R10 low at third edge", drq_tx, 1'b0);
      cyc(2);
      ack_release();
      chk("R7 re-arm n=2", drq_tx, 1'b1);
      dma_write(); ack_release();
      chk("R8 n=2 done", drq_tx, 1'b0);

      // directed blocks
      tx_block(0, 0);
      tx_block(1, 0);
      tx_block(64, 0);
      tx_block(65, 0);
      tx_block(130, 100);
      tx_block(3, 100);

      // R1 + R9: receive block
      rx_blk_len = 16'd3;
      rx_blk_ready = 1'b1; cyc(1); rx_blk_ready = 1'b0; cyc(3);
      chk("R9 rx request raised", drq_rx, 1'b1);
      chk("R1 tx unaffected by rx", drq_tx, 1'b0);
      base = rx_pops;
      dma_read();
      chk("R9 rx held after first", drq_rx, 1'b1);
      ack_release();
      dma_read();
      chk("R9 rx drop at n-1", drq_rx, 1'b0);
      rx_blk_len = 16'd100;
      rx_blk_ready = 1'b1; cyc(1); rx_blk_ready = 1'b0; cyc(3);
      chk("R9 ready while active ignored", drq_rx, 1'b0);
      ack_release();
      chk("R9 rx re-arm", drq_rx, 1'b1);
      dma_read(); ack_release();
      chk("R9 rx done, extra ready ignored", drq_rx, 1'b0);
      chk_n("R9 rx pops", rx_pops - base, 3);
      chk("R1 tx still low", drq_tx, 1'b0);

      // random blocks
      for (int b = 0; b < 5; b++) begin
         tx_block($urandom_range(1, 200), 30);
      end

      // R11: reset mid-block
      tx_start(10);
      chk("R4 start before reset", drq_tx, 1'b1);
      rst = 1'b1; cyc(2); rst = 1'b0; cyc(2);
      chk("R11 reset clears request", drq_tx, 1'b0);
      ack_release();
      chk("R11 no re-arm after reset", drq_tx, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule